// File: doc/BRIEF.md
# Time-Multiplexed Multichannel FIR Filter

This block runs several slow sample streams through one finite impulse response datapath. The streams share a single fast stream, one sample per clock, and each sample carries the number of the channel it belongs to. The filter is in transposed form: every incoming sample is multiplied by all coefficients at once. Each product is added to the partial sum that the same channel left behind on its previous sample. Between neighbouring taps a bank with one entry per channel keeps the pending partial sums. Entries are read and written at the channel number of the current sample, so sums from different channels never meet.

The output is one registered stream in the order samples were accepted. It carries the filtered value and the channel number of the sample that produced it. Both edges use a valid/ready handshake. A sample moves when `s_valid` and `s_ready` are both high at a rising edge. A result moves when `m_valid` and `m_ready` are both high. While a result waits on a low `m_ready`, the block holds it unchanged and refuses new input. Arithmetic is signed two's complement and is never rounded or clipped. The result width is the sample width plus the coefficient width plus the bits that the number of taps adds. The coefficients are fixed by parameter. Coefficient i multiplies the sample that is i samples old within its channel, and the coefficient with the highest index is added next to a constant zero.

Top module: `tdm_fir`

## Requirements
- R1: For channel c, each result equals the sum over i of COEFS[i] times the sample of channel c accepted i samples earlier in that channel. i = 0 is the sample just accepted. Coefficient i sits in COEFS bits [i*CW +: CW], signed.
- R2: Per-channel histories stay separate whatever order the channel numbers arrive in, including repeats and gaps. A legal `s_chan` is below NCH.
- R3: Reset clears every stored partial sum. The first results of each channel after reset therefore see an all-zero history.
- R4: A sample accepted at an edge yields its result at that same edge: `m_valid` is high after it, and `m_chan` equals the sample's channel. Outputs come out in acceptance order. A result taken with no new input accepted leaves `m_valid` low.
- R5: While `m_valid` is high and `m_ready` is low, `m_data` and `m_chan` hold their values.
- R6: A cycle without a transfer (low `s_valid` or low `s_ready`) changes no stored partial sum. Later results are the same as if that cycle had been skipped.
- R7: The result is the full SW-bit signed sum with no rounding or saturation. With the default widths, all-minimum inputs produce no wrap.
- R8: After reset, `m_valid` is low and `s_ready` is high.
- R9: `s_ready` is high exactly when the output register is empty or is being emptied in the same cycle (`!m_valid || m_ready`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample offered |
| s_ready | output | 1 | Block can take the offered sample |
| s_data | input | DW | Signed input sample |
| s_chan | input | CHW | Channel number of the input sample |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer takes the result |
| m_data | output | SW | Signed filtered result |
| m_chan | output | CHW | Channel number of the result |

## Verification
The first pattern sweeps every possible sample value over the channels in strict rotation. This ties each coefficient to its age slot and shows any mix-up between taps. The next pattern pushes saturating extremes on some channels and small values on others, which exposes truncation of the sum. After that, channels arrive in random order with repeats, and input gaps and output stalls are also random. Any sharing of partial sums between channels shows up here, as does any state change in a cycle with no transfer. A final reset in mid-stream, followed by impulses, shows whether old history survives the reset.

// File: rtl/tdm_fir_pkg.sv
package tdm_fir_pkg;

  // Width of the accumulated result: product width plus growth from summing taps.
  function automatic int sum_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps);
  endfunction

endpackage

// File: rtl/tdm_fir_mac.sv
module tdm_fir_mac #(
  parameter int DW = 9,
  parameter int CW = 9,
  parameter int SW = 20,
  parameter logic signed [CW-1:0] K = '0
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [SW-1:0] acc_in,
  output logic signed [SW-1:0] y
);

  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic signed [SW-1:0] prod_ext;

  always_comb begin
    prod     = x * K;
    prod_ext = SW'(prod);
    y        = acc_in + prod_ext;
  end

endmodule

// File: rtl/tdm_fir_chan_bank.sv
module tdm_fir_chan_bank #(
  parameter int NCH = 4,
  parameter int CHW = 2,
  parameter int SW  = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [CHW-1:0]       addr,
  input  logic signed [SW-1:0] wd,
  output logic signed [SW-1:0] rd
);

  logic [NCH-1:0][SW-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (we) begin
      mem[addr] <= wd;
    end
  end

  assign rd = mem[addr];

  AST_BANK_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem)); // R6

  AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(addr)] == $past(wd)); // R2

  AST_BANK_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> int'(addr) < NCH); // R2

endmodule

// File: rtl/tdm_fir_out_stage.sv
module tdm_fir_out_stage #(
  parameter int SW  = 20,
  parameter int CHW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 in_fire,
  input  logic signed [SW-1:0] in_data,
  input  logic [CHW-1:0]       in_chan,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [SW-1:0]        m_data,
  output logic [CHW-1:0]       m_chan
);

  assign in_ready = !m_valid || m_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_chan  <= '0;
    end else if (in_fire) begin
      m_valid <= 1'b1;
      m_data  <= in_data;
      m_chan  <= in_chan;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan))); // R5

  AST_ONE_CYCLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (m_valid && m_chan == $past(in_chan))); // R4

  AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !in_fire) |=> !m_valid); // R4

endmodule

// File: rtl/tdm_fir.sv
module tdm_fir
  import tdm_fir_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 9,
  parameter int CW   = 9,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEFS = {9'h1FD, 9'h07F, 9'h100, 9'h005},
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SW  = sum_width(DW, CW, TAPS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           s_valid,
  output logic           s_ready,
  input  logic [DW-1:0]  s_data,
  input  logic [CHW-1:0] s_chan,
  output logic           m_valid,
  input  logic           m_ready,
  output logic [SW-1:0]  m_data,
  output logic [CHW-1:0] m_chan
);

  logic                 fire;
  logic signed [DW-1:0] x;
  logic signed [SW-1:0] carry [TAPS];
  logic signed [SW-1:0] chain [TAPS];

  assign x = s_data;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    tdm_fir_mac #(
      .DW(DW), .CW(CW), .SW(SW), .K(COEFS[i*CW +: CW])
    ) u_mac (
      .x      (x),
      .acc_in (carry[i]),
      .y      (chain[i])
    );

    if (i == TAPS - 1) begin : g_tail
      assign carry[i] = '0;
    end else begin : g_bank
      tdm_fir_chan_bank #(
        .NCH(NCH), .CHW(CHW), .SW(SW)
      ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (fire),
        .addr  (s_chan),
        .wd    (chain[i+1]),
        .rd    (carry[i])
      );
    end
  end

  tdm_fir_out_stage #(
    .SW(SW), .CHW(CHW)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (s_valid),
    .in_ready (s_ready),
    .in_fire  (fire),
    .in_data  (chain[0]),
    .in_chan  (s_chan),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_data),
    .m_chan   (m_chan)
  );

  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |-> int'(s_chan) < NCH); // R2

  AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_valid) |-> $past(s_valid && s_ready)); // R4

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_chan) || !$past(s_valid)); // R9

endmodule

// File: tb/tdm_fir_tb.sv
`timescale 1ns/1ps
module tdm_fir_tb;

  localparam int NCH = 4;
  localparam int CHW = 2;
  localparam int SW  = 20;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [8:0]     s_data = '0;
  logic [CHW-1:0] s_chan = '0;
  logic           m_valid;
  logic           m_ready = 1'b1;
  logic [SW-1:0]  m_data;
  logic [CHW-1:0] m_chan;

  int coef [4] = '{5, -256, 127, -3};
  int hist [NCH][4];
  int exp_q [$];
  int chq [$];
  int checks = 0;
  int failures = 0;
  string tag = "R1";
  bit exp_mvalid = 0;
  bit prev_stall = 0;
  logic [SW-1:0]  prev_data = '0;
  logic [CHW-1:0] prev_chan = '0;

  always #2.5 clk = ~clk;

  tdm_fir u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_chan(s_chan),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan)
  );

  task automatic chk(input bit ok, input string t, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 4; i++) hist[c][i] = 0;
    exp_q.delete();
    chq.delete();
    exp_mvalid = 0;
    prev_stall = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_valid = 1'b0;
    m_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    #1;
    chk(m_valid == 1'b0, "R8 m_valid", m_valid, 0);
    chk(s_ready == 1'b1, "R8 s_ready", s_ready, 1);
  endtask

  task automatic step(input bit v, input int ch, input int d, input bit rdy);
    int acc;
    int act;
    @(negedge clk);
    s_valid = v;
    s_chan  = ch[CHW-1:0];
    s_data  = d[8:0];
    m_ready = rdy;
    #1;
    chk(m_valid == exp_mvalid, "R4 m_valid", m_valid, exp_mvalid);
    if (prev_stall) begin
      chk(m_data == prev_data, "R5 m_data held", m_data, prev_data);
      chk(m_chan == prev_chan, "R5 m_chan held", m_chan, prev_chan);
    end
    chk(s_ready == (!m_valid || m_ready), "R9 s_ready", s_ready, !m_valid || m_ready);
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", 1, 0);
      end else begin
        act = int'($signed(m_data));
        chk(act == exp_q[0], tag, act, exp_q[0]);
        chk(int'(m_chan) == chq[0], "R4 m_chan", m_chan, chq[0]);
        void'(exp_q.pop_front());
        void'(chq.pop_front());
      end
    end
    if (v && s_ready) begin
      for (int i = 3; i > 0; i--) hist[ch][i] = hist[ch][i-1];
      hist[ch][0] = d;
      acc = 0;
      for (int i = 0; i < 4; i++) acc += coef[i] * hist[ch][i];
      exp_q.push_back(acc);
      chq.push_back(ch);
    end
    exp_mvalid = (v && s_ready) || (m_valid && !m_ready);
    prev_stall = m_valid && !m_ready;
    prev_data  = m_data;
    prev_chan  = m_chan;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    clear_model();
    do_reset();

    // R1: every sample value, channels in strict rotation
    tag = "R1 result";
    for (int v = -256; v < 256; v++) step(1, (v + 256) % NCH, v, 1);
    for (int i = 0; i < 16; i++) step(1, i % NCH, 0, 1);

    // R7: extremes on channels 0/1, small values on 2/3
    tag = "R7 full width";
    for (int i = 0; i < 40; i++) begin
      step(1, 0, -256, 1);
      step(1, 1, (i % 2) ? 255 : -256, 1);
      step(1, 2, 1, 1);
      step(1, 3, -1, 1);
    end

    // R2: random channel order with repeats
    tag = "R2 channel isolation";
    for (int i = 0; i < 2000; i++)
      step(1, int'($urandom_range(NCH-1, 0)), int'($urandom_range(511, 0)) - 256, 1);

    // R6 / R5: random gaps on input and stalls on output
    tag = "R6 idle cycles";
    for (int i = 0; i < 3000; i++)
      step($urandom_range(1, 0) == 1, int'($urandom_range(NCH-1, 0)),
           int'($urandom_range(511, 0)) - 256, $urandom_range(3, 0) != 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);

    // R3: reset in mid-stream with history present, then impulses
    for (int i = 0; i < 12; i++) step(1, i % NCH, 77 - i, 1);
    do_reset();
    tag = "R3 cleared history";
    for (int c = 0; c < NCH; c++) step(1, c, 100 + c, 1);
    for (int i = 0; i < 4 * NCH; i++) step(1, i % NCH, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1);

    chk(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    finish_run();
  end

endmodule